// File: doc/BRIEF.md
# Multifunction 32-bit ALU

This block is the combinational arithmetic and logic unit of a small load/store processor. It takes two 32-bit operands, `x` and `y`, and a 5-bit control word. It returns a 32-bit result together with a signed-overflow flag and a zero flag. The block holds no state. Every output follows its inputs within the same cycle.

The control word has three fields:
- Bits 4:3 hold the function class, which picks the source of the result: 00 places an upper immediate, 01 gives a set-on-less-than, 10 gives the adder result and 11 gives a bitwise logic operation.
- Bits 2:1 pick the logic operation.
- Bit 0 puts the single adder into subtract mode.

The set-on-less-than class has no comparator of its own. It reuses the adder's sign together with the adder's overflow condition. The instruction decoder asserts bit 0 for subtract and for both compare forms.

Top module: `alu32`

## Requirements
- R1: With class 10 and bit 0 clear, `result` equals `x + y` modulo 2^32.
- R2: With class 10 and bit 0 set, `result` equals `x - y` modulo 2^32.
- R3: `ovfl` is 1 exactly when the class is 10 and the add or subtract selected by bit 0 overflows as a two's-complement signed operation. It is 0 in every other class.
- R4: With class 01 and bit 0 set, `result` is 1 when `x` is less than `y` as signed 32-bit integers and 0 otherwise. This holds for extreme operands such as 0x80000000 against 0x7FFFFFFF. Bits 31:1 are always 0.
- R5: With class 01 and bit 0 clear, `result` is 1 exactly when the signed sum `x + y`, taken without wraparound, is negative. Bits 31:1 are 0.
- R6: With class 11, bits 2:1 select the operation: 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives NOR of `x` and `y`.
- R7: With class 00, `result[31:16]` equals `y[15:0]` and `result[15:0]` is 0. The value of `x` has no effect.
- R8: `zero` is 1 exactly when all 32 bits of `result` are 0, in every class.
- R9: Bits 2:1 have no effect on any output unless the class is 11. Bit 0 has no effect on any output when the class is 00 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | 32 | First operand |
| y | input | 32 | Second operand; its low half supplies the upper-immediate value |
| ctrlWord | input | 5 | Bits 4:3 function class, bits 2:1 logic select, bit 0 subtract |
| result | output | 32 | Selected 32-bit result |
| ovfl | output | 1 | Signed overflow of the add/subtract, only in the arithmetic class |
| zero | output | 1 | High when the result is all zeros |

## Verification
The block holds no state, so a wrong decode or a wrong carry into the adder shows at the ports in the same cycle as the stimulus that triggers it. No other input has to come first.

The bench steps through all 32 control words. For each one it applies directed corner operands and then random operands:
- The corner operands are the overflow boundaries and equal operands, which give a zero difference.
- The random operands come after the corners.

A wrong set-on-less-than path shows up only when the operands have opposite signs and large magnitudes. That is why 0x80000000 against 0x7FFFFFFF and against 1 are always among the applied operands.

Leakage from control bits that should be ignored shows as a mismatch against the model on the same operands under a different encoding.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned CTRL_W = 5;

  typedef enum logic [1:0] {
    FC_UPPER = 2'b00,
    FC_LESS  = 2'b01,
    FC_ARITH = 2'b10,
    FC_LOGIC = 2'b11
  } fnClass_e;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_XOR = 2'b10,
    LF_NOR = 2'b11
  } logicFn_e;

  typedef struct packed {
    fnClass_e fnClass;
    logicFn_e logicFn;
    logic     subtract;
  } ctrlWord_t;

  typedef struct packed {
    logic     pickUpper;
    logic     pickLess;
    logic     pickArith;
    logic     pickLogic;
    logic     subtract;
    logicFn_e logicFn;
    logic     ovflEnable;
  } strobes_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  ctrlWord_t cw,
  output strobes_t  strobes
);
  always_comb begin
    strobes            = '0;
    strobes.subtract   = cw.subtract;
    strobes.logicFn    = cw.logicFn;
    unique case (cw.fnClass)
      FC_UPPER: strobes.pickUpper = 1'b1;
      FC_LESS:  strobes.pickLess  = 1'b1;
      FC_ARITH: begin
        strobes.pickArith  = 1'b1;
        strobes.ovflEnable = 1'b1;
      end
      default:  strobes.pickLogic = 1'b1;
    endcase
  end

  // one source selected for every control word
  always_comb begin
    a_r9_one_source: assert ($countones({strobes.pickUpper, strobes.pickLess,
                                          strobes.pickArith, strobes.pickLogic}) == 1)
      else $error("ALU control selected no source or more than one");
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             signedOvfl,
  output logic             trueNegative
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] opBEff;

  always_comb begin
    opBEff       = subtract ? ~opB : opB;
    sum          = opA + opBEff + {{(WIDTH-1){1'b0}}, subtract};
    signedOvfl   = (opA[MSB] == opBEff[MSB]) && (sum[MSB] != opA[MSB]);
    trueNegative = sum[MSB] ^ signedOvfl;
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logicFn_e         fn,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    unique case (fn)
      LF_AND:  out = opA & opB;
      LF_OR:   out = opA | opB;
      LF_XOR:  out = opA ^ opB;
      default: out = ~(opA | opB);
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] result,
  output logic             ovfl,
  output logic             zero
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] upperOut;
  logic             addOvfl;
  logic             lessBit;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opA(x), .opB(y), .subtract(strobes.subtract),
    .sum(sum), .signedOvfl(addOvfl), .trueNegative(lessBit)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .opA(x), .opB(y), .fn(strobes.logicFn), .out(logicOut)
  );

  always_comb begin
    upperOut = {y[HALF-1:0], {(WIDTH-HALF){1'b0}}};
    result   = '0;
    if (strobes.pickUpper) result = upperOut;
    if (strobes.pickLess)  result = {{(WIDTH-1){1'b0}}, lessBit};
    if (strobes.pickArith) result = sum;
    if (strobes.pickLogic) result = logicOut;
    ovfl = addOvfl & strobes.ovflEnable;
    zero = (result == '0);
  end

  always_comb begin
    // R3: no overflow outside the arithmetic class
    a_r3_no_overflow: assert (strobes.pickArith || !ovfl)
      else $error("overflow raised outside arithmetic class");
    // R4/R5: compare results occupy bit 0 only
    a_r4_less_single_bit: assert (!strobes.pickLess || result[WIDTH-1:1] == '0)
      else $error("compare result has upper bits set");
    // R7: upper placement clears the low half and copies y low half
    a_r7_upper_place: assert (!strobes.pickUpper ||
                              (result[HALF-1:0] == '0 && result[WIDTH-1:HALF] == y[HALF-1:0]))
      else $error("upper immediate misplaced");
    // R2/R8: equal operands subtracted give a zero flag
    a_r8_equal_sub_zero: assert (!(strobes.pickArith && strobes.subtract && x == y) || zero)
      else $error("x-x did not raise zero");
    // R1: adding zero passes x through
    a_r1_add_identity: assert (!(strobes.pickArith && !strobes.subtract && y == '0) || result == x)
      else $error("x+0 differs from x");
  end
endmodule

// File: rtl/alu32.sv
module alu32
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  x,
  input  logic [WIDTH-1:0]  y,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [WIDTH-1:0]  result,
  output logic              ovfl,
  output logic              zero
);
  strobes_t strobes;

  alu_ctrl u_ctrl (
    .cw(ctrlWord_t'(ctrlWord)),
    .strobes(strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .x(x), .y(y), .strobes(strobes),
    .result(result), .ovfl(ovfl), .zero(zero)
  );
endmodule

// File: tb/alu32_tb.sv
module alu32_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] x = '0;
  logic [31:0] y = '0;
  logic [4:0]  cw = '0;
  logic [31:0] result;
  logic        ovfl;
  logic        zero;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alu32 u_dut (.x(x), .y(y), .ctrlWord(cw), .result(result), .ovfl(ovfl), .zero(zero));

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] c, output logic [31:0] r,
                                output logic ov, output logic z);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t  = c[0] ? sa - sb : sa + sb;
    logic wide = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    case (c[4:3])
      2'b00: r = {b[15:0], 16'h0000};
      2'b01: r = (t < 0) ? 32'd1 : 32'd0;
      2'b10: r = t[31:0];
      default: case (c[2:1])
        2'b00: r = a & b;
        2'b01: r = a | b;
        2'b10: r = a ^ b;
        default: r = ~(a | b);
      endcase
    endcase
    ov = (c[4:3] == 2'b10) && wide;
    z  = (r == 32'd0);
  endfunction

  function automatic string tagOf(input logic [4:0] c);
    if ((c[4:3] != 2'b11 && c[2:1] != 2'b00) ||
        ((c[4:3] == 2'b00 || c[4:3] == 2'b11) && c[0])) return "R9";
    case (c[4:3])
      2'b00: return "R7";
      2'b01: return c[0] ? "R4" : "R5";
      2'b10: return c[0] ? "R2" : "R1";
      default: return "R6";
    endcase
  endfunction

  task automatic applyAndCheck(input logic [31:0] a, input logic [31:0] b, input logic [4:0] c);
    logic [31:0] er;
    logic eo, ez;
    @(posedge clk);
    #1;
    x = a; y = b; cw = c;
    @(negedge clk);
    model(a, b, c, er, eo, ez);
    total++;
    if (result !== er) begin
      bad++;
      $display("FAIL %s result cw=%b x=%h y=%h actual=%h expected=%h", tagOf(c), c, a, b, result, er);
    end
    total++;
    if (ovfl !== eo) begin
      bad++;
      $display("FAIL R3 ovfl cw=%b x=%h y=%h actual=%b expected=%b", c, a, b, ovfl, eo);
    end
    total++;
    if (zero !== ez) begin
      bad++;
      $display("FAIL R8 zero cw=%b x=%h y=%h actual=%b expected=%b", c, a, b, zero, ez);
    end
  endtask

  initial begin
    logic [31:0] corners [8];
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h8000_0001;
    corners[6] = 32'h1234_5678; corners[7] = 32'hFFFF_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs give upper class with zero result (R7, R8)
    total++;
    if (result !== 32'd0 || ovfl !== 1'b0 || zero !== 1'b1) begin
      bad++;
      $display("FAIL R8 reset actual=%h/%b/%b expected=00000000/0/1", result, ovfl, zero);
    end
    rst = 1'b0;
    for (int c = 0; c < 32; c++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyAndCheck(corners[i], corners[j], 5'(c));
      for (int k = 0; k < 120; k++) begin
        logic [31:0] ra = $urandom;
        logic [31:0] rb = (k % 10 == 0) ? ra : $urandom;
        applyAndCheck(ra, rb, 5'(c));
      end
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule